// File: doc/BRIEF.md
# SPI Receive Status and Buffering Logic

This block holds the status byte and the receive side storage of a 16-bit SPI peripheral. An external shifter hands it each finished word as a one-cycle strobe with 16 data bits. The block also sees the occupancy of the transmit queue and a mode-fault pulse. A CPU reaches it over a small byte-wide register bus. Combinational read data covers five addresses: status at 0, received data high byte at 1, received data low byte at 2, match register high byte at 3 and match register low byte at 4.

Two receive modes exist. In single-buffer mode each word overwrites one holding register. In FIFO mode words go into a four-deep queue, and a low-byte data read pops the oldest entry. The receive-full flag and the match flag clear only through two-step sequences. Each sequence starts with a status read taken while the flag is set. Any change of the master, FIFO-mode or enable configuration inputs starts a status reset. The values that reset gives the FIFO-related flags depend on the new FIFO-mode setting.

Top module: `spi_rx_status`

## Requirements
- R1: After power-on reset the status byte reads 0x20: the transmit-empty flag (bit 5) is 1 and every other flag is 0, including bits 2 and 0 when FIFO mode is on. The bit layout is: 7 receive full, 6 match, 5 transmit empty, 4 mode fault, 3 receive nearly full, 2 transmit near empty, 1 transmit full, 0 receive FIFO empty.
- R2: In single-buffer mode a received word sets bit 7. Reading address 1 gives the word's upper byte and address 2 its lower byte, and a newer word overwrites an older one.
- R3: In single-buffer mode bit 7 clears only when a read of address 2 follows a status read made while bit 7 was 1. A read of address 2 without that earlier status read leaves bit 7 set.
- R4: A word that arrives between the status read and the data read cancels the armed first step, so the data read does not clear bit 7.
- R5: Bit 6 sets one cycle after a word equal to the match register (written high byte at address 3, low byte at address 4) is accepted, and only if bit 7 is 1 in that cycle. A word that does not match never sets it.
- R6: Bit 6 clears only on a status write with data bit 6 equal to 1 that follows a status read made while bit 6 was 1. A write without that read, or a write with data bit 6 equal to 0, leaves it set.
- R7: A change of any configuration input clears the FIFO, the single buffer and bits 7, 6 and 4, and sets bit 5. It sets bits 2 and 0 to the new FIFO-mode value.
- R8: In FIFO mode bit 0 is 1 when the queue holds no words, bit 3 when it holds three or more, and bit 7 once it holds four.
- R9: In FIFO mode, data reads return words oldest first, and a read of address 2 pops the entry. A word that arrives while the queue holds four is dropped, and the stored words are kept.
- R10: In FIFO mode bit 7 stays set while the queue drains. It clears on the pop that empties the queue, unless a word arrives in that same cycle.
- R11: In FIFO mode bit 2 is 1 when the transmit occupancy is 2 or less, and bit 1 is 1 when it equals 4. Both are 0 in single-buffer mode. Bit 5 follows an occupancy of 0, one cycle later.
- R12: A mode-fault pulse sets bit 4, which stays set until a configuration change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_master | input | 1 | Master-mode configuration bit |
| cfg_fifo_en | input | 1 | FIFO-mode configuration bit |
| cfg_enable | input | 1 | Peripheral enable configuration bit |
| rx_valid | input | 1 | One-cycle strobe: a word has been received |
| rx_word | input | 16 | Received word, valid with rx_valid |
| tx_count | input | 3 | Occupancy of the transmit queue, 0 to 4 |
| mode_fault | input | 1 | Mode-fault event pulse |
| reg_addr | input | 3 | Register address (0 status, 1/2 data, 3/4 match) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |

## Verification
The bench goes after the ordering rules of both clear sequences. A design that clears on a lone data read, on a lone write of 1, or on a write of 0 would show a cleared flag where the bench expects it still set. A design that forgets to cancel the armed step on a new arrival would show bit 7 cleared after the intervening word. A sweep that loads zero to six words into the queue checks the empty, nearly-full and full flags against the count, the oldest-first order, and the dropping of words past four. A design that overwrote stored entries, or released the full flag on the first pop, would miss those values. Simultaneous pop-and-arrival on the last entry, configuration-driven reset values, and the transmit occupancy sweep in both modes cover the remaining corners.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;
    localparam int MATCH_BIT = 6;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS = 3'd0,
        ADR_DAT_HI = 3'd1,
        ADR_DAT_LO = 3'd2,
        ADR_MAT_HI = 3'd3,
        ADR_MAT_LO = 3'd4
    } reg_addr_e;

    // Status byte: first field is bit 7
    typedef struct packed {
        logic rx_full;
        logic match;
        logic tx_empty;
        logic mode_fault;
        logic rx_nfull;
        logic tx_near;
        logic tx_full;
        logic rx_empty;
    } stat_t;

    typedef struct packed {
        logic master;
        logic fifo_en;
        logic enable;
    } cfg_t;

    function automatic logic [BUS_W-1:0] upper_byte(input logic [15:0] w);
        return w[15:8];
    endfunction

    function automatic logic [BUS_W-1:0] lower_byte(input logic [15:0] w);
        return w[7:0];
    endfunction

endpackage

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WORD_W-1:0]            din,
    input  logic                         pop,
    output logic [WORD_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   count_next,
    output logic                         push_ok,
    output logic                         pop_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wp_q, rp_q;
    logic [CW-1:0]     cnt_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok  = !flush && pop && (cnt_q != '0);
    assign push_ok = !flush && push && ((cnt_q != FULL) || pop_ok);

    always_comb begin
        count_next = cnt_q;
        if (flush)
            count_next = '0;
        else if (push_ok && !pop_ok)
            count_next = cnt_q + 1'b1;
        else if (!push_ok && pop_ok)
            count_next = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            cnt_q <= count_next;
            if (push_ok) wp_q <= step(wp_q);
            if (pop_ok)  rp_q <= step(rp_q);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && wp_q == PW'(i)) mem[i] <= din;
        end
    end

    assign head  = mem[rp_q];
    assign count = cnt_q;

    // R9
    fifo_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    // R9
    overflow_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL && push && !pop && !flush) |=> (cnt_q == FULL && $stable(wp_q)));

endmodule

// File: rtl/spi_seq_arm.sv
module spi_seq_arm (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic arm,
    input  logic fire,
    input  logic cancel,
    output logic armed,
    output logic clear
);
    logic armed_q;

    assign clear = armed_q && fire && !cancel;
    assign armed = armed_q;

    always_ff @(posedge clk) begin
        if (rst || flush || cancel)
            armed_q <= 1'b0;
        else if (armed_q && fire)
            armed_q <= 1'b0;
        else if (arm)
            armed_q <= 1'b1;
    end

    // R4
    cancel_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !armed_q);

endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
    import spi_rx_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int TX_DEPTH    = 4,
    parameter int TX_NEAR_LVL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_fifo_en,
    input  logic              cfg_enable,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_word,
    input  logic [$clog2(TX_DEPTH+1)-1:0] tx_count,
    input  logic              mode_fault,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata
);
    localparam int CW  = $clog2(FIFO_DEPTH + 1);
    localparam int TCW = $clog2(TX_DEPTH + 1);
    localparam logic [CW-1:0]  RX_FULL  = CW'(FIFO_DEPTH);
    localparam logic [CW-1:0]  RX_NEAR  = CW'(FIFO_DEPTH - 1);
    localparam logic [TCW-1:0] TX_FULLC = TCW'(TX_DEPTH);
    localparam logic [TCW-1:0] TX_NEARC = TCW'(TX_NEAR_LVL);

    // configuration change detect
    cfg_t cfg_now, cfg_q;
    logic soft_rst;
    assign cfg_now  = {cfg_master, cfg_fifo_en, cfg_enable};
    assign soft_rst = (cfg_now != cfg_q);

    always_ff @(posedge clk) cfg_q <= cfg_now;

    // bus decode
    logic st_rd, dlo_rd, st_wr_m;
    assign st_rd   = reg_rd && (reg_addr == ADR_STATUS);
    assign dlo_rd  = reg_rd && (reg_addr == ADR_DAT_LO);
    assign st_wr_m = reg_wr && (reg_addr == ADR_STATUS) && reg_wdata[MATCH_BIT];

    // match register
    logic [DATA_W-1:0] match_q;
    always_ff @(posedge clk) begin
        if (rst) match_q <= '0;
        else if (reg_wr && reg_addr == ADR_MAT_HI) match_q[15:8] <= reg_wdata;
        else if (reg_wr && reg_addr == ADR_MAT_LO) match_q[7:0]  <= reg_wdata;
    end

    // receive storage
    logic [DATA_W-1:0] fifo_head, sbuf_q;
    logic [CW-1:0]     fifo_cnt, fifo_cnt_nx;
    logic              push_ok, pop_ok;

    spi_rx_fifo #(.WORD_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .flush      (soft_rst),
        .push       (cfg_fifo_en && rx_valid),
        .din        (rx_word),
        .pop        (cfg_fifo_en && dlo_rd),
        .head       (fifo_head),
        .count      (fifo_cnt),
        .count_next (fifo_cnt_nx),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst) sbuf_q <= '0;
        else if (!cfg_fifo_en && rx_valid) sbuf_q <= rx_word;
    end

    logic rx_evt;
    assign rx_evt = cfg_fifo_en ? push_ok : rx_valid;

    // flag registers
    logic rx_full_q, match_f_q, tx_empty_q, modf_q, tx_near_q, rx_empty_q, chk_q;
    logic rx_armed, rx_clear, m_armed, m_clear;

    spi_seq_arm u_rx_arm (
        .clk    (clk),
        .rst    (rst),
        .flush  (soft_rst),
        .arm    (st_rd && rx_full_q && !cfg_fifo_en),
        .fire   (dlo_rd && !cfg_fifo_en),
        .cancel (rx_evt),
        .armed  (rx_armed),
        .clear  (rx_clear)
    );

    spi_seq_arm u_match_arm (
        .clk    (clk),
        .rst    (rst),
        .flush  (soft_rst),
        .arm    (st_rd && match_f_q),
        .fire   (st_wr_m),
        .cancel (rx_evt),
        .armed  (m_armed),
        .clear  (m_clear)
    );

    logic rx_full_nx;
    always_comb begin
        rx_full_nx = rx_full_q;
        if (soft_rst)
            rx_full_nx = 1'b0;
        else if (!cfg_fifo_en) begin
            if (rx_valid)      rx_full_nx = 1'b1;
            else if (rx_clear) rx_full_nx = 1'b0;
        end else begin
            if (push_ok && fifo_cnt_nx == RX_FULL) rx_full_nx = 1'b1;
            else if (pop_ok && fifo_cnt_nx == '0)  rx_full_nx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full_q  <= 1'b0;
            match_f_q  <= 1'b0;
            chk_q      <= 1'b0;
            tx_empty_q <= 1'b1;
            modf_q     <= 1'b0;
            tx_near_q  <= 1'b0;
            rx_empty_q <= 1'b0;
        end else if (soft_rst) begin
            rx_full_q  <= 1'b0;
            match_f_q  <= 1'b0;
            chk_q      <= 1'b0;
            tx_empty_q <= 1'b1;
            modf_q     <= 1'b0;
            tx_near_q  <= cfg_fifo_en;
            rx_empty_q <= cfg_fifo_en;
        end else begin
            rx_full_q  <= rx_full_nx;
            chk_q      <= rx_evt && (rx_word == match_q);
            if (chk_q && rx_full_q) match_f_q <= 1'b1;
            else if (m_clear)       match_f_q <= 1'b0;
            tx_empty_q <= (tx_count == '0);
            if (mode_fault) modf_q <= 1'b1;
            tx_near_q  <= cfg_fifo_en && (tx_count <= TX_NEARC);
            rx_empty_q <= cfg_fifo_en && (fifo_cnt_nx == '0);
        end
    end

    stat_t stat;
    always_comb begin
        stat.rx_full    = rx_full_q;
        stat.match      = match_f_q;
        stat.tx_empty   = tx_empty_q;
        stat.mode_fault = modf_q;
        stat.rx_nfull   = cfg_fifo_en && (fifo_cnt >= RX_NEAR);
        stat.tx_near    = tx_near_q;
        stat.tx_full    = cfg_fifo_en && (tx_count == TX_FULLC);
        stat.rx_empty   = rx_empty_q;
    end

    // read mux
    logic [DATA_W-1:0] rd_word;
    assign rd_word = cfg_fifo_en ? fifo_head : sbuf_q;

    always_comb begin
        unique case (reg_addr)
            ADR_STATUS: reg_rdata = stat;
            ADR_DAT_HI: reg_rdata = upper_byte(rd_word);
            ADR_DAT_LO: reg_rdata = lower_byte(rd_word);
            ADR_MAT_HI: reg_rdata = upper_byte(match_q);
            ADR_MAT_LO: reg_rdata = lower_byte(match_q);
            default:    reg_rdata = '0;
        endcase
    end

    // R5
    match_after_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(match_f_q) |-> $past(rx_full_q));

    // R3
    rx_clear_seq_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rx_full_q) && !$past(soft_rst) && !$past(cfg_fifo_en)) |-> ($past(dlo_rd) && $past(rx_armed)));

    // R6
    match_clear_seq_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(match_f_q) && !$past(soft_rst)) |-> ($past(st_wr_m) && $past(m_armed)));

    // R8
    nfull_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        stat.rx_nfull |-> !stat.rx_empty);

    // R10
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_fifo_en && rx_full_q && !soft_rst && !dlo_rd) |=> rx_full_q);

    // R12
    modf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (modf_q && !soft_rst) |=> modf_q);

endmodule

// File: tb/tb_spi_rx_status.sv
module tb_spi_rx_status;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_master, cfg_fifo_en, cfg_enable;
    logic        rx_valid;
    logic [15:0] rx_word;
    logic [2:0]  tx_count;
    logic        mode_fault;
    logic [2:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    spi_rx_status dut (
        .clk(clk), .rst(rst),
        .cfg_master(cfg_master), .cfg_fifo_en(cfg_fifo_en), .cfg_enable(cfg_enable),
        .rx_valid(rx_valid), .rx_word(rx_word), .tx_count(tx_count),
        .mode_fault(mode_fault),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic push(input logic [15:0] w);
        rx_valid = 1'b1; rx_word = w;
        tick();
        rx_valid = 1'b0;
        tick();
    endtask

    task automatic set_fifo(input logic f);
        cfg_fifo_en = f;
        tick();
        tick();
    endtask

    function automatic logic [15:0] wk(input int k);
        return 16'h1000 + 16'(k) * 16'h0111;
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, h;
        rst = 1'b1; cfg_master = 1'b1; cfg_fifo_en = 1'b1; cfg_enable = 1'b1;
        rx_valid = 1'b0; rx_word = '0; tx_count = '0; mode_fault = 1'b0;
        reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(3'd0, d);
        chk("R1 power-on status with FIFO mode on", {8'h0, d}, 16'h0020);
        cfg_fifo_en = 1'b0;
        tick();
        rst = 1'b0;
        tick();
        rd(3'd0, d);
        chk("R1 status after reset release", {8'h0, d}, 16'h0020);

        // single-buffer mode
        push(16'h3C96);
        rd(3'd2, d);          // data read with no armed status read
        rd(3'd0, d);
        chk("R3 lone data read keeps bit7", {8'h0, d & 8'h80}, 16'h0080);
        push(16'h5A0F);       // cancels the arm just made
        rd(3'd1, h);
        rd(3'd2, d);
        chk("R2 single buffer data", {h, d}, 16'h5A0F);
        rd(3'd0, d);
        chk("R4 arrival cancels armed step", {8'h0, d & 8'h80}, 16'h0080);
        rd(3'd2, d);
        rd(3'd0, d);
        chk("R3 two-step clear of bit7", {8'h0, d & 8'h80}, 16'h0000);

        // match flag
        wr(3'd3, 8'hA5);
        wr(3'd4, 8'h5A);
        rd(3'd3, h); rd(3'd4, d);
        chk("R5 match register readback", {h, d}, 16'hA55A);
        push(16'hA55A);
        rd(3'd0, d);
        chk("R5 match sets after bit7", {8'h0, d & 8'hC0}, 16'h00C0);
        push(16'h1234);       // cancels the match arm
        wr(3'd0, 8'h40);
        rd(3'd0, d);
        chk("R6 write without status read keeps bit6", {8'h0, d & 8'h40}, 16'h0040);
        wr(3'd0, 8'h00);
        rd(3'd0, d);
        chk("R6 write of 0 keeps bit6", {8'h0, d & 8'h40}, 16'h0040);
        wr(3'd0, 8'h40);
        rd(3'd0, d);
        chk("R6 two-step clear of bit6", {8'h0, d & 8'h40}, 16'h0000);
        push(16'h1235);
        rd(3'd0, d);
        chk("R5 mismatching word leaves bit6", {8'h0, d & 8'hC0}, 16'h0080);

        // mode fault
        mode_fault = 1'b1; tick(); mode_fault = 1'b0;
        repeat (3) tick();
        rd(3'd0, d);
        chk("R12 mode fault sticky", {8'h0, d & 8'h10}, 16'h0010);

        // configuration change resets
        set_fifo(1'b1);
        rd(3'd0, d);
        chk("R7 reset into FIFO mode", {8'h0, d}, 16'h0025);
        set_fifo(1'b0);
        rd(3'd0, d);
        chk("R7 reset into single-buffer mode", {8'h0, d}, 16'h0020);

        // FIFO sweep over 0..6 arrivals, match on the 4th word
        wr(3'd3, wk(3)[15:8]);
        wr(3'd4, wk(3)[7:0]);
        for (int n = 0; n <= 6; n++) begin
            logic [7:0] e;
            set_fifo(1'b1);
            for (int k = 0; k < n; k++) push(wk(k));
            e = {n >= 4, n >= 4, 1'b1, 1'b0, n >= 3, 1'b1, 1'b0, n == 0};
            rd(3'd0, d);
            chk($sformatf("R8 FIFO flags n=%0d", n), {8'h0, d}, {8'h0, e});
            if (n >= 1 && n <= 3)
                chk($sformatf("R5 no match while bit7 low n=%0d", n), {8'h0, d & 8'h40}, 16'h0000);
            for (int j = 0; j < ((n > 4) ? 4 : n); j++) begin
                rd(3'd1, h);
                rd(3'd2, d);
                chk($sformatf("R9 FIFO order n=%0d j=%0d", n, j), {h, d}, wk(j));
                if (j == 0 && n >= 4) begin
                    rd(3'd0, d);
                    chk($sformatf("R10 bit7 held while draining n=%0d", n), {8'h0, d & 8'h80}, 16'h0080);
                end
            end
            if (n > 0) begin
                rd(3'd0, d);
                chk($sformatf("R10 bit7 clear when empty n=%0d", n), {8'h0, d & 8'h81}, 16'h0001);
            end
            set_fifo(1'b0);
        end

        // last pop with simultaneous arrival
        set_fifo(1'b1);
        for (int k = 0; k < 4; k++) push(wk(k));
        for (int k = 0; k < 3; k++) rd(3'd2, d);
        reg_addr = 3'd2; reg_rd = 1'b1; rx_valid = 1'b1; rx_word = 16'hBEEF;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0; rx_valid = 1'b0;
        tick();
        chk("R9 last entry before refill", {8'h0, d}, {8'h0, wk(3)[7:0]});
        rd(3'd0, d);
        chk("R10 pop with arrival keeps bit7", {8'h0, d & 8'h81}, 16'h0080);
        rd(3'd1, h); rd(3'd2, d);
        chk("R9 refilled word", {h, d}, 16'hBEEF);
        rd(3'd0, d);
        chk("R10 bit7 clears after final pop", {8'h0, d & 8'h81}, 16'h0001);

        // transmit occupancy sweep in both modes
        for (int m = 1; m >= 0; m--) begin
            set_fifo(m[0]);
            for (int c = 0; c <= 4; c++) begin
                logic [7:0] e;
                tx_count = 3'(c);
                tick();
                e = {2'b00, c == 0, 2'b00, (m == 1) && (c <= 2), (m == 1) && (c == 4), 1'b0};
                rd(3'd0, d);
                chk($sformatf("R11 tx flags mode=%0d count=%0d", m, c), {8'h0, d & 8'h26}, {8'h0, e});
            end
            tx_count = '0;
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule